// File: doc/BRIEF.md
# Video Sync Polarity and Blanking Stage

This stage sits on the video path between a raster timing generator and the output pins. It takes raw active-high horizontal and vertical sync pulses, a display-enable strobe and a 24-bit RGB pixel. It applies a per-sync polarity choice, and it can hold either sync or both syncs at their inactive level for display power management. It can also flag a composite sync for sync-on-green signalling. A display-off control forces the pixel data to black.

A narrow write-only register port loads two control words. The sync word carries the polarity, suppression and sync-on-green bits. The display word carries the display-off bit. Software reaches the usual power states by writing one sync word and one display word:

- Unblank: display word 0x00 and sync word with bits 1, 5 and 6 clear.
- Power-down: display word 0x02 and sync word 0x02.
- Horizontal suspend: display word 0x02 and sync word 0x20.
- Vertical suspend: display word 0x02 and sync word 0x40.

Every output leaves a register, so sync, enable and pixel data stay aligned behind one fixed cycle of latency.

Top module: `vid_sync_blank`

## Requirements
- R1: While reset is asserted, every output is low. After reset, the sync word is 0 and the display-off bit is set, so the pixel output is black until software clears the display-off bit.
- R2: Asserting cfg_we with cfg_sel=0 loads the sync word, and cfg_sel=1 loads the display word. A word written at clock edge k governs the inputs sampled at edge k+1 and every later edge.
- R3: Every output takes the value computed from the inputs sampled at the previous rising edge, which is exactly one cycle of latency.
- R4: Sync word bit 3 inverts hsync_out and bit 4 inverts vsync_out. A set bit makes that sync active-low.
- R5: Sync word bit 5 holds hsync_out at its inactive level, which is the value of bit 3.
- R6: Sync word bit 6 holds vsync_out at its inactive level, which is the value of bit 4.
- R7: Sync word bit 1 holds both syncs at their inactive levels and forces sog_out low.
- R8: When sync word bit 0 is set and bit 1 is clear, sog_out is the active-high OR of those of hsync_in and vsync_in that are not suppressed. sog_out does not depend on the inversion bits. When bit 0 is clear, sog_out is low.
- R9: Display word bit 1 forces rgb_out to zero and de_out low. The other bits of the display word have no effect.
- R10: When de_in is low, rgb_out is zero and de_out is low. Otherwise de_out follows de_in and rgb_out follows rgb_in.
- R11: Sync word bits 2 and 7 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Word select: 0 sync word, 1 display word |
| cfg_wdata | input | CFG_W | Write data |
| hsync_in | input | 1 | Raw active-high horizontal sync |
| vsync_in | input | 1 | Raw active-high vertical sync |
| de_in | input | 1 | Display enable from timing generator |
| rgb_in | input | PIX_W | Pixel data, three channels of CH_W bits |
| hsync_out | output | 1 | Horizontal sync after polarity and suppression |
| vsync_out | output | 1 | Vertical sync after polarity and suppression |
| sog_out | output | 1 | Composite sync flag that travels with green |
| de_out | output | 1 | Gated display enable |
| rgb_out | output | PIX_W | Pixel data, black when blanked |

## Verification
A register write and a live sync or pixel transition can land on the same clock edge. This matters when software changes polarity or power state in the middle of a line. The bench provokes this by issuing random sync and display words on random cycles while the sync, enable and pixel inputs toggle every cycle. A behavioural model applies each word from the edge after its write, and every output is compared on every clock. The first pixel after a write must use the old control value, and the next pixel must use the new one.

// File: rtl/vsb_pkg.sv
package vsb_pkg;

    // Bit positions inside the sync control word
    localparam int SB_SOG     = 0;
    localparam int SB_ALL_OFF = 1;
    localparam int SB_H_INV   = 3;
    localparam int SB_V_INV   = 4;
    localparam int SB_H_OFF   = 5;
    localparam int SB_V_OFF   = 6;

    // Bit position inside the display control word
    localparam int DB_OFF     = 1;

    localparam logic SEL_SYNC = 1'b0;
    localparam logic SEL_DISP = 1'b1;

    typedef struct packed {
        logic sog_en;
        logic all_off;
        logic h_inv;
        logic v_inv;
        logic h_off;
        logic v_off;
    } sync_cfg_t;

    typedef struct packed {
        sync_cfg_t sync;
        logic      disp_off;
    } ctrl_state_t;

endpackage

// File: rtl/vsb_ctrl_regs.sv
module vsb_ctrl_regs
    import vsb_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             sel,
    input  logic [CFG_W-1:0] wdata,
    output sync_cfg_t        sync_q,
    output logic             disp_off_q
);

    ctrl_state_t st_d, st_q;

    // Bits 2, 7 and above of the sync word, and all but one display bit, are dropped
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (sel == SEL_SYNC) begin
                st_d.sync.sog_en  = wdata[SB_SOG];
                st_d.sync.all_off = wdata[SB_ALL_OFF];
                st_d.sync.h_inv   = wdata[SB_H_INV];
                st_d.sync.v_inv   = wdata[SB_V_INV];
                st_d.sync.h_off   = wdata[SB_H_OFF];
                st_d.sync.v_off   = wdata[SB_V_OFF];
            end else begin
                st_d.disp_off     = wdata[DB_OFF];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.disp_off <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_q     = st_q.sync;
    assign disp_off_q = st_q.disp_off;

endmodule

// File: rtl/vsb_sync_lane.sv
module vsb_sync_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic inv,
    input  logic off,
    output logic live,
    output logic sync_o
);

    logic sync_d, sync_q;

    // Unsuppressed raw pulse, used for the composite flag
    assign live = raw & ~off;

    always_comb begin
        if (off) sync_d = inv;
        else     sync_d = raw ^ inv;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/vsb_pixel_gate.sv
module vsb_pixel_gate #(
    parameter int CH_W   = 8,
    parameter int NUM_CH = 3,
    localparam int PIX_W = CH_W * NUM_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             de_in,
    input  logic [PIX_W-1:0] rgb_in,
    input  logic             disp_off,
    output logic             de_out,
    output logic [PIX_W-1:0] rgb_out
);

    typedef struct packed {
        logic             de;
        logic [PIX_W-1:0] rgb;
    } pix_t;

    pix_t        px_d, px_q;
    logic        keep;
    logic [PIX_W-1:0] gated;

    assign keep = de_in & ~disp_off;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign gated[c*CH_W +: CH_W] = keep ? rgb_in[c*CH_W +: CH_W] : '0;
    end

    always_comb begin
        px_d.de  = keep;
        px_d.rgb = gated;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) px_q <= '0;
        else        px_q <= px_d;
    end

    assign de_out  = px_q.de;
    assign rgb_out = px_q.rgb;

endmodule

// File: rtl/vid_sync_blank.sv
module vid_sync_blank
    import vsb_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int NUM_CH = 3,
    parameter int CFG_W  = 8,
    localparam int PIX_W = CH_W * NUM_CH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic             de_in,
    input  logic [PIX_W-1:0] rgb_in,
    output logic             hsync_out,
    output logic             vsync_out,
    output logic             sog_out,
    output logic             de_out,
    output logic [PIX_W-1:0] rgb_out
);

    localparam int N_LANE = 2;

    sync_cfg_t cfg_sync;
    logic      cfg_disp_off;

    vsb_ctrl_regs #(.CFG_W(CFG_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cfg_we),
        .sel        (cfg_sel),
        .wdata      (cfg_wdata),
        .sync_q     (cfg_sync),
        .disp_off_q (cfg_disp_off)
    );

    // Lane 0 is horizontal, lane 1 vertical
    logic [N_LANE-1:0] lane_raw, lane_inv, lane_off, lane_live, lane_out;

    assign lane_raw = {vsync_in, hsync_in};
    assign lane_inv = {cfg_sync.v_inv, cfg_sync.h_inv};
    assign lane_off = {cfg_sync.v_off | cfg_sync.all_off,
                       cfg_sync.h_off | cfg_sync.all_off};

    for (genvar i = 0; i < N_LANE; i++) begin : g_lane
        vsb_sync_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw    (lane_raw[i]),
            .inv    (lane_inv[i]),
            .off    (lane_off[i]),
            .live   (lane_live[i]),
            .sync_o (lane_out[i])
        );
    end

    assign hsync_out = lane_out[0];
    assign vsync_out = lane_out[1];

    logic sog_d, sog_q;

    always_comb begin
        sog_d = cfg_sync.sog_en & ~cfg_sync.all_off & (|lane_live);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sog_q <= 1'b0;
        else        sog_q <= sog_d;
    end

    assign sog_out = sog_q;

    vsb_pixel_gate #(.CH_W(CH_W), .NUM_CH(NUM_CH)) u_pix (
        .clk      (clk),
        .rst_n    (rst_n),
        .de_in    (de_in),
        .rgb_in   (rgb_in),
        .disp_off (cfg_disp_off),
        .de_out   (de_out),
        .rgb_out  (rgb_out)
    );

endmodule

// File: rtl/vid_sync_blank_chk.sv
module vid_sync_blank_chk #(
    parameter int PIX_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hs_in,
    input logic             de_in,
    input logic             hs_out,
    input logic             vs_out,
    input logic             sog_out,
    input logic             de_out,
    input logic [PIX_W-1:0] rgb_out,
    input logic             c_sog_en,
    input logic             c_all_off,
    input logic             c_h_inv,
    input logic             c_v_inv,
    input logic             c_h_off,
    input logic             c_v_off,
    input logic             c_disp_off
);

    // R4: an enabled hsync follows its input through the chosen polarity
    a_r4_hs_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_h_off && !c_all_off) |=> (hs_out == ($past(hs_in) ^ $past(c_h_inv))));

    // R5: a suppressed hsync sits at its inactive level
    a_r5_hs_held: assert property (@(posedge clk) disable iff (!rst_n)
        (c_h_off || c_all_off) |=> (hs_out == $past(c_h_inv)));

    // R6: a suppressed vsync sits at its inactive level
    a_r6_vs_held: assert property (@(posedge clk) disable iff (!rst_n)
        (c_v_off || c_all_off) |=> (vs_out == $past(c_v_inv)));

    // R7 and R8: the composite flag is quiet when disabled or all sync is off
    a_r8_sog_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_sog_en || c_all_off) |=> !sog_out);

    // R9: display off yields black and no enable
    a_r9_black: assert property (@(posedge clk) disable iff (!rst_n)
        c_disp_off |=> (rgb_out == '0 && !de_out));

    // R10: no enable yields black
    a_r10_de_low: assert property (@(posedge clk) disable iff (!rst_n)
        !de_in |=> (rgb_out == '0 && !de_out));

endmodule

bind vid_sync_blank vid_sync_blank_chk #(.PIX_W(PIX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_in      (hsync_in),
    .de_in      (de_in),
    .hs_out     (hsync_out),
    .vs_out     (vsync_out),
    .sog_out    (sog_out),
    .de_out     (de_out),
    .rgb_out    (rgb_out),
    .c_sog_en   (cfg_sync.sog_en),
    .c_all_off  (cfg_sync.all_off),
    .c_h_inv    (cfg_sync.h_inv),
    .c_v_inv    (cfg_sync.v_inv),
    .c_h_off    (cfg_sync.h_off),
    .c_v_off    (cfg_sync.v_off),
    .c_disp_off (cfg_disp_off)
);

// File: tb/vid_sync_blank_bench.sv
module vid_sync_blank_bench;

    localparam int CH_W  = 8;
    localparam int NUM_CH = 3;
    localparam int CFG_W = 8;
    localparam int PIX_W = CH_W * NUM_CH;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic             hsync_in = 1'b0, vsync_in = 1'b0, de_in = 1'b0;
    logic [PIX_W-1:0] rgb_in = '0;
    logic             hsync_out, vsync_out, sog_out, de_out;
    logic [PIX_W-1:0] rgb_out;

    vid_sync_blank #(.CH_W(CH_W), .NUM_CH(NUM_CH), .CFG_W(CFG_W)) u_vid_sync_blank (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .de_in(de_in), .rgb_in(rgb_in), .hsync_out(hsync_out),
        .vsync_out(vsync_out), .sog_out(sog_out), .de_out(de_out),
        .rgb_out(rgb_out)
    );

    int    checks = 0;
    int    errors = 0;
    string phase  = "R1";
    bit    done   = 0;

    // Behavioural model of the control state
    bit m_sog, m_all, m_hinv, m_vinv, m_hoff, m_voff;
    bit m_doff = 1'b1;
    // Write issued at the last negedge, taking effect at the following posedge
    bit pw = 0, psel = 0;
    logic [7:0] pdat = '0;
    // Expected outputs after the next posedge
    logic e_hs = 0, e_vs = 0, e_sog = 0, e_de = 0;
    logic [PIX_W-1:0] e_rgb = '0;

    task automatic chk(string tag, string nm, logic [PIX_W-1:0] act, logic [PIX_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (phase %s) %s actual=%h expected=%h at %0t",
                     tag, phase, nm, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string th, tv, ts, tp;
        th = m_all ? "R7" : (m_hoff ? "R5" : "R4");
        tv = m_all ? "R7" : (m_voff ? "R6" : "R4");
        ts = m_all ? "R7" : "R8";
        tp = m_doff ? "R9" : "R10";
        chk(th, "hsync_out", PIX_W'(hsync_out), PIX_W'(e_hs));
        chk(tv, "vsync_out", PIX_W'(vsync_out), PIX_W'(e_vs));
        chk(ts, "sog_out",   PIX_W'(sog_out),   PIX_W'(e_sog));
        chk(tp, "de_out",    PIX_W'(de_out),    PIX_W'(e_de));
        chk(tp, "rgb_out",   rgb_out,           e_rgb);
    endtask

    // One pixel clock: check the previous result, then drive the next inputs
    task automatic step(bit we, bit sel, logic [7:0] d,
                        bit h, bit v, bit de, logic [PIX_W-1:0] rgb);
        @(negedge clk);
        compare_all();
        if (pw) begin
            if (psel == 1'b0) begin
                m_sog  = pdat[0]; m_all  = pdat[1];
                m_hinv = pdat[3]; m_vinv = pdat[4];
                m_hoff = pdat[5]; m_voff = pdat[6];
            end else begin
                m_doff = pdat[1];
            end
        end
        pw = we; psel = sel; pdat = d;
        cfg_we = we; cfg_sel = sel; cfg_wdata = CFG_W'(d);
        hsync_in = h; vsync_in = v; de_in = de; rgb_in = rgb;
        e_hs  = (m_all | m_hoff) ? m_hinv : (h ^ m_hinv);
        e_vs  = (m_all | m_voff) ? m_vinv : (v ^ m_vinv);
        e_sog = m_sog & ~m_all & ((h & ~m_hoff) | (v & ~m_voff));
        e_de  = de & ~m_doff;
        e_rgb = (de && !m_doff) ? rgb : '0;
    endtask

    task automatic run_pixels(int n);
        for (int i = 0; i < n; i++)
            step(0, 0, 8'h00, 1'($urandom), 1'($urandom), 1'($urandom), PIX_W'($urandom));
    endtask

    task automatic set_word(bit sel, logic [7:0] d);
        step(1, sel, d, 1'($urandom), 1'($urandom), 1'($urandom), PIX_W'($urandom));
    endtask

    initial begin
        // R1: outputs low while reset is held, even with active inputs
        hsync_in = 1; vsync_in = 1; de_in = 1; rgb_in = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset hsync_out", PIX_W'(hsync_out), '0);
        chk("R1", "reset vsync_out", PIX_W'(vsync_out), '0);
        chk("R1", "reset sog_out",   PIX_W'(sog_out),   '0);
        chk("R1", "reset de_out",    PIX_W'(de_out),    '0);
        chk("R1", "reset rgb_out",   rgb_out,           '0);
        hsync_in = 0; vsync_in = 0; de_in = 0; rgb_in = '0;
        rst_n = 1'b1;

        // R1: display stays black after reset until cleared
        phase = "R1";
        run_pixels(40);

        // R3 and R10: plain pass-through with display on
        phase = "R3";
        set_word(1, 8'h00);
        run_pixels(80);

        // R4: polarity choices
        phase = "R4";
        set_word(0, 8'h08); run_pixels(40);
        set_word(0, 8'h10); run_pixels(40);
        set_word(0, 8'h18); run_pixels(40);

        // R5, R6: individual suppression with and without inversion
        phase = "R5";
        set_word(0, 8'h20); run_pixels(40);
        set_word(0, 8'h28); run_pixels(40);
        phase = "R6";
        set_word(0, 8'h40); run_pixels(40);
        set_word(0, 8'h50); run_pixels(40);

        // R7: power-down state
        phase = "R7";
        set_word(1, 8'h02); set_word(0, 8'h1B); run_pixels(40);

        // R8: composite sync flag, alone and with suppression
        phase = "R8";
        set_word(1, 8'h00);
        set_word(0, 8'h01); run_pixels(40);
        set_word(0, 8'h19); run_pixels(40);
        set_word(0, 8'h21); run_pixels(40);
        set_word(0, 8'h41); run_pixels(40);

        // R11: unused sync bits
        phase = "R11";
        set_word(0, 8'h84); run_pixels(40);
        set_word(0, 8'h9D); run_pixels(40);

        // R9: display word, other bits ignored
        phase = "R9";
        set_word(1, 8'hFD); run_pixels(40);
        set_word(1, 8'h02); run_pixels(40);
        set_word(1, 8'hFF); run_pixels(40);
        set_word(1, 8'h00); run_pixels(20);

        // R2: writes colliding with live sync and pixel edges
        phase = "R2";
        for (int i = 0; i < 2000; i++)
            step(1'($urandom), 1'($urandom), 8'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), PIX_W'($urandom));
        run_pixels(4);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired in phase %s", phase);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule